// File: doc/BRIEF.md
# Paired PWM Clock Tree with Shared Prescaler

This block drives two PWM outputs whose clock trees share some stages. A two-way source selector picks either a fixed oscillator tick or a bus clock tick. A power-of-two divider, common to both channels, then slows the selected tick. After the divider, each channel has its own linear prescaler and its own period and duty counter. Both sources are one-cycle tick enables inside a single system clock domain.

Configuration arrives on a small write port. Each write carries a channel number, an address and data. The channel number names the channel that owns the write: the requester for a shared-setting write, or the target for a per-channel write. The channels share the source and divider, so lock logic protects them. A write to those shared settings is refused while the other channel is running. The refused write is dropped and a sticky error flag is raised. With both channels idle, the first channel to write and enable fixes the pair's clock resolution.

Per-channel period and duty values are staged and take effect at the next counter wrap, so a change never leaves a cut-short pulse. The active source select and divider value are visible as outputs. This lets software confirm whether a shared write took effect.

Top module: `pwm_pair_clk`

## Requirements
- R1: After reset the source select is 0 (oscillator), the divider value is 0, the error flag is 0 and both outputs are low.
- R2: With the shared divider value M and a channel prescale value k (address 1, data bits 7:0), the channel counter advances once per 2^M*(k+1) selected source ticks. Each channel uses its own k.
- R3: The source is chosen by bit 0 of a shared write (address 0): 0 selects the oscillator tick input and 1 selects the bus tick input.
- R4: The period P is written at address 2 and the duty D at address 3, both 16 bits. The channel counter runs from 0 to P-1 and then wraps to 0. The output is high while the counter is below D, so D=0 gives a constant low and D>=P gives a constant high.
- R5: A shared write (address 0; bit 0 is the source, bits 7:4 are M) is accepted only when the other channel is disabled. Otherwise the write is ignored and the source and divider keep their values.
- R6: A refused shared write sets the error flag one cycle later. The flag stays set until data bit 0 is written as 1 at address 5.
- R7: An accepted shared write with M above 8 stores M as 8.
- R8: New period and duty values take effect only when the running channel's counter wraps, or at once while the channel is disabled.
- R9: Bit 0 of a write at address 4 enables (1) or disables (0) the channel. A disabled channel drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle tick from the fixed oscillator |
| bus_tick | input | 1 | One-cycle tick from the bus clock |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 1 | Channel the write targets or requests for |
| wr_addr | input | 3 | Write address: 0 shared, 1 prescale, 2 period, 3 duty, 4 enable, 5 error clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 2 | PWM outputs, bit i belongs to channel i |
| src_sel | output | 1 | Active source select (0 oscillator, 1 bus) |
| div_m | output | 4 | Active shared divider value |
| lock_err | output | 1 | Sticky error flag for a refused shared write |

## Verification
Configuration registers, the error flag and the visible source and divider values change at the clock edge that samples the write. The bench reads them at the falling edge after that write completes. Output waveforms depend on the phase of the free-running divider, so the bench never times single edges for them. Instead it waits at least two full PWM periods after enabling and then counts high cycles over a whole number of periods, which gives a count independent of phase: D of every P counter steps, each lasting 2^M*(k+1) source ticks. The wrap-only update is checked relative to an observed rising edge. The bench writes a smaller duty one counter step into the period and samples three steps in, where immediate and deferred updates give opposite levels.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int NCH     = 2;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 8;
    localparam int DIV_MAX = 8;
    localparam int M_W     = 4;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_SHARED   = 3'd0,
        A_PRESCALE = 3'd1,
        A_PERIOD   = 3'd2,
        A_DUTY     = 3'd3,
        A_ENABLE   = 3'd4,
        A_ERRCLR   = 3'd5
    } addr_e;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_BUS = 1'b1
    } src_e;

    typedef struct packed {
        logic [PRE_W-1:0] k;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             en;
    } chan_cfg_t;

    function automatic logic [M_W-1:0] clamp_m(input logic [M_W-1:0] m);
        return (m > M_W'(DIV_MAX)) ? M_W'(DIV_MAX) : m;
    endfunction

endpackage

// File: rtl/pwm_pair_cfg.sv
module pwm_pair_cfg
    import pwm_pair_pkg::*;
#(
    parameter int ADDR_WID = ADDR_W,
    parameter int DATA_WID = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_ch,
    input  logic [ADDR_WID-1:0]     wr_addr,
    input  logic [DATA_WID-1:0]     wr_data,
    output src_e                    src_o,
    output logic [M_W-1:0]          m_o,
    output chan_cfg_t [NCH-1:0]     cfg_o,
    output logic                    err_o
);

    logic partner_en;
    logic shared_wr;
    logic shared_ok;

    assign partner_en = wr_ch ? cfg_o[0].en : cfg_o[1].en;
    assign shared_wr  = wr_en && (wr_addr == A_SHARED);
    assign shared_ok  = shared_wr && !partner_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_o <= SRC_OSC;
            m_o   <= '0;
            err_o <= 1'b0;
            cfg_o <= '0;
        end else begin
            if (shared_ok) begin
                src_o <= src_e'(wr_data[0]);
                m_o   <= clamp_m(wr_data[7:4]);
            end
            if (shared_wr && partner_en) begin
                err_o <= 1'b1;
            end else if (wr_en && wr_addr == A_ERRCLR && wr_data[0]) begin
                err_o <= 1'b0;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_PRESCALE: cfg_o[wr_ch].k      <= wr_data[PRE_W-1:0];
                    A_PERIOD:   cfg_o[wr_ch].period <= wr_data[CNT_W-1:0];
                    A_DUTY:     cfg_o[wr_ch].duty   <= wr_data[CNT_W-1:0];
                    A_ENABLE:   cfg_o[wr_ch].en     <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    // R5: a shared write while the partner runs leaves the shared settings alone
    p_lock_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (shared_wr && partner_en) |=> ($stable(src_o) && $stable(m_o) && err_o));

    // R7: an accepted oversized divider value lands on the maximum
    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        (shared_ok && wr_data[7:4] > 4'd8) |=> (m_o == 4'd8));

    // R6: the flag only drops on an explicit clear
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (err_o && !(wr_en && wr_addr == A_ERRCLR && wr_data[0])) |=> err_o);

endmodule

// File: rtl/pwm_pow2_div.sv
module pwm_pow2_div
    import pwm_pair_pkg::*;
#(
    parameter int MW   = M_W,
    parameter int DMAX = DIV_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic          bus_tick,
    input  src_e          src,
    input  logic [MW-1:0] m,
    output logic          div_tick
);

    logic            sel_tick;
    logic [DMAX-1:0] cnt;
    logic [DMAX-1:0] lim;
    logic [MW-1:0]   m_q;
    src_e            src_q;
    logic            changed;

    assign sel_tick = (src == SRC_BUS) ? bus_tick : osc_tick;
    assign lim      = DMAX'(({{DMAX{1'b0}}, 1'b1} << m) - 1'b1);
    assign changed  = (m != m_q) || (src != src_q);
    assign div_tick = sel_tick && (cnt == lim) && !changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            m_q   <= '0;
            src_q <= SRC_OSC;
        end else begin
            m_q   <= m;
            src_q <= src;
            if (changed) begin
                cnt <= '0;
            end else if (sel_tick) begin
                cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
            end
        end
    end

    // R2: with M at least 1 two divider ticks never come back to back
    p_div_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (div_tick && m_q != '0) |=> !div_tick);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pair_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      div_tick,
    input  chan_cfg_t cfg,
    output logic      pwm
);

    logic [PW-1:0] pcnt;
    logic [CW-1:0] ccnt;
    logic [CW-1:0] per_act;
    logic [CW-1:0] duty_act;
    logic          ch_tick;
    logic          wrap;
    logic          load;

    assign ch_tick = div_tick && (pcnt == cfg.k);
    assign wrap    = ({1'b0, ccnt} + 1'b1) >= {1'b0, per_act};
    assign load    = !cfg.en || (ch_tick && wrap);
    assign pwm     = cfg.en && (ccnt < duty_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt     <= '0;
            ccnt     <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else if (!cfg.en) begin
            pcnt     <= '0;
            ccnt     <= '0;
            per_act  <= cfg.period;
            duty_act <= cfg.duty;
        end else begin
            if (div_tick) begin
                pcnt <= ch_tick ? '0 : pcnt + 1'b1;
            end
            if (ch_tick) begin
                if (wrap) begin
                    ccnt     <= '0;
                    per_act  <= cfg.period;
                    duty_act <= cfg.duty;
                end else begin
                    ccnt <= ccnt + 1'b1;
                end
            end
        end
    end

    // R9: a disabled channel sits with cleared counters
    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (ccnt == '0 && pcnt == '0));

    // R4: the counter stays inside the active period
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (per_act != '0) |-> (ccnt < per_act));

    // R8: active period and duty move only on a load event
    p_reload_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(per_act) || !$stable(duty_act)) |-> $past(load));

endmodule

// File: rtl/pwm_pair_clk.sv
module pwm_pair_clk
    import pwm_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        bus_tick,
    input  logic        wr_en,
    input  logic        wr_ch,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [1:0]  pwm_out,
    output logic        src_sel,
    output logic [3:0]  div_m,
    output logic        lock_err
);

    src_e                src;
    logic [M_W-1:0]      m;
    chan_cfg_t [NCH-1:0] cfg;
    logic                div_tick;

    pwm_pair_cfg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .src_o   (src),
        .m_o     (m),
        .cfg_o   (cfg),
        .err_o   (lock_err)
    );

    pwm_pow2_div i_div (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .bus_tick (bus_tick),
        .src      (src),
        .m        (m),
        .div_tick (div_tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_chan i_chan (
            .clk      (clk),
            .rst      (rst),
            .div_tick (div_tick),
            .cfg      (cfg[c]),
            .pwm      (pwm_out[c])
        );
    end

    assign src_sel = src;
    assign div_m   = m;

endmodule

// File: tb/test_pwm_pair_clk.sv
module test_pwm_pair_clk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic        bus_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_ch = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pwm_out;
    logic        src_sel;
    logic [3:0]  div_m;
    logic        lock_err;

    int checks = 0;
    int errors = 0;
    int osc_div = 1;
    int bus_div = 3;
    int ph = 0;
    bit done = 0;

    pwm_pair_clk i_pwm_pair_clk (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .src_sel(src_sel), .div_m(div_m), .lock_err(lock_err)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            ph = ph + 1;
            osc_tick = (ph % osc_div) == 0;
            bus_tick = (ph % bus_div) == 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int ch, input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) n++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    // one channel with period/duty, given M and k, oscillator source
    task automatic run_div(input int m, input int k, input string tag);
        int t, n;
        wr(0, 3'd4, 16'd0);
        wr(1, 3'd4, 16'd0);
        wr(0, 3'd0, 16'(m << 4));
        wr(0, 3'd1, 16'(k));
        wr(0, 3'd2, 16'd2);
        wr(0, 3'd3, 16'd1);
        wr(0, 3'd4, 16'd1);
        t = 2 * (1 << m) * (k + 1);
        repeat (2 * t + 4) @(negedge clk);
        count_high(0, 4 * t, n);
        chk(n == 2 * t, tag, n, 2 * t);
    endtask

    initial begin
        int n, exp;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(src_sel == 1'b0, "R1 source", src_sel, 0);
        chk(div_m == 4'd0, "R1 divider", div_m, 0);
        chk(lock_err == 1'b0, "R1 error", lock_err, 0);
        chk(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);

        for (int m = 0; m <= 8; m++) run_div(m, 0, "R2 divider sweep");
        run_div(0, 1, "R2 prescale 1");
        run_div(0, 5, "R2 prescale 5");
        run_div(0, 255, "R2 prescale 255");
        run_div(3, 2, "R2 combined");

        // R4 duty sweep, period 5
        wr(0, 3'd4, 16'd0);
        wr(0, 3'd0, 16'd0);
        wr(0, 3'd1, 16'd0);
        wr(0, 3'd2, 16'd5);
        for (int d = 0; d <= 6; d++) begin
            wr(0, 3'd4, 16'd0);
            wr(0, 3'd3, 16'(d));
            wr(0, 3'd4, 16'd1);
            repeat (12) @(negedge clk);
            count_high(0, 20, n);
            exp = 4 * ((d < 5) ? d : 5);
            chk(n == exp, "R4 duty sweep", n, exp);
        end

        // R3 bus source, both channels with own prescale
        wr(0, 3'd4, 16'd0);
        wr(0, 3'd0, 16'h0011);
        chk(src_sel == 1'b1, "R3 select bus", src_sel, 1);
        wr(0, 3'd1, 16'd0); wr(0, 3'd2, 16'd2); wr(0, 3'd3, 16'd1);
        wr(1, 3'd1, 16'd1); wr(1, 3'd2, 16'd2); wr(1, 3'd3, 16'd1);
        wr(0, 3'd4, 16'd1);
        wr(1, 3'd4, 16'd1);
        repeat (60) @(negedge clk);
        count_high(0, 48, n);
        chk(n == 24, "R3 bus channel0", n, 24);
        count_high(1, 96, n);
        chk(n == 48, "R2 independent k channel1", n, 48);

        // R5/R6 lock rules: both running, ch0 requests
        wr(0, 3'd0, 16'h0020);
        chk(div_m == 4'd1 && src_sel == 1'b1, "R5 both enabled rejected", div_m, 1);
        chk(lock_err == 1'b1, "R6 error set", lock_err, 1);
        wr(1, 3'd4, 16'd0);
        chk(lock_err == 1'b1, "R6 error sticky", lock_err, 1);
        wr(0, 3'd5, 16'd1);
        chk(lock_err == 1'b0, "R6 error cleared", lock_err, 0);
        // only requester enabled: accepted
        wr(0, 3'd0, 16'h0030);
        chk(div_m == 4'd3 && src_sel == 1'b0, "R5 sole requester accepted", div_m, 3);
        chk(lock_err == 1'b0, "R6 no error on accept", lock_err, 0);
        // partner running: ch1 request rejected
        wr(1, 3'd0, 16'h0051);
        chk(div_m == 4'd3 && src_sel == 1'b0, "R5 partner running rejected", div_m, 3);
        chk(lock_err == 1'b1, "R6 error after partner reject", lock_err, 1);
        wr(0, 3'd5, 16'd1);

        // R7 clamp while idle
        wr(0, 3'd4, 16'd0);
        wr(1, 3'd0, 16'h00C0);
        chk(div_m == 4'd8, "R7 clamp", div_m, 8);

        // R9 disabled output low while ticks run
        wr(0, 3'd0, 16'd0);
        wr(0, 3'd3, 16'd5);
        count_high(0, 40, n);
        chk(n == 0, "R9 disabled ch0 low", n, 0);
        count_high(1, 40, n);
        chk(n == 0, "R9 disabled ch1 low", n, 0);

        // R8 duty change deferred to wrap: M0 k9 period 8 duty 4
        wr(0, 3'd1, 16'd9);
        wr(0, 3'd2, 16'd8);
        wr(0, 3'd3, 16'd4);
        wr(0, 3'd4, 16'd1);
        repeat (170) @(negedge clk);
        wait_rise(0);
        repeat (10) @(negedge clk);
        wr(0, 3'd3, 16'd2);
        repeat (16) @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R8 old duty holds until wrap", pwm_out[0], 1);
        wait_rise(0);
        count_high(0, 80, n);
        chk(n == 20, "R8 new duty after wrap", n, 20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule